// File: doc/BRIEF.md
# Staggered SDRAM Refresh Sequencer

This block generates periodic auto-refresh cycles for up to four SDRAM chip-select banks. A down-counter, loaded from a programmable interval, raises a refresh request each time it expires. The request is held until the memory arbiter pulses a grant in a cycle where the shared address/data bus is idle and the previous memory transaction has completed. Only then does the block drive its active-low strobes through a column-before-row refresh.

A configuration bit picks the refresh style. In the simultaneous style every chip select drops together with both strobes for one clock. In the walking style the chip selects fall one at a time, one clock apart, while both strobes stay low, which spreads the supply current drawn by the banks. After reset the interval is 512 clocks and the walking style is active. A configuration write replaces the interval and the style at once and restarts the counter. The style is captured when a sequence starts.

Top module: `stagger_refresh_seq`

## Requirements
- R1: During and right after reset, csN, rasN and casN are all high, refReq and refDone are low. The reset interval is 512 clocks and the reset style is walking (cfgStagger = 1 selects walking, 0 selects simultaneous).
- R2: refReq goes high exactly N clock edges after the edge that loaded interval N, whether the load came from reset or from a configuration write (cfgWe sampled high). The counter reloads itself after each expiry.
- R3: An interval of zero never raises refReq.
- R4: Expiries that occur while a request is already pending merge into that one request. refReq drops on the edge where a sequence starts, and exactly one sequence is run for it.
- R5: A sequence starts only on an edge where refReq, refGnt, busIdle and xferDone are all high. A grant at any other time is ignored: no strobe moves and refReq is unchanged.
- R6: One edge after the start edge, casN alone is low, with rasN and all csN high.
- R7: In the simultaneous style, the next cycle has all csN, rasN and casN low for exactly one clock.
- R8: In the walking style, the next four cycles have rasN and casN low and exactly one csN bit low, bank 0 first and then in ascending order.
- R9: After the last row cycle, all strobes return high together, and refDone is high for that single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Loads cfgInterval and cfgStagger and restarts the counter |
| cfgInterval | input | 16 | Refresh interval in clocks, 0 disables requests |
| cfgStagger | input | 1 | 1 selects walking chip selects, 0 selects simultaneous |
| refGnt | input | 1 | One-cycle grant from the memory arbiter |
| busIdle | input | 1 | Shared address/data bus is idle |
| xferDone | input | 1 | Last SDRAM or device transaction has finished |
| refReq | output | 1 | Refresh request pending |
| csN | output | 4 | Active-low chip selects, one per bank |
| rasN | output | 1 | Active-low row strobe |
| casN | output | 1 | Active-low column strobe |
| refDone | output | 1 | One-cycle pulse as the strobes return high |

## Verification
refReq is due exactly N edges after the loading edge, so the bench counts edges from that edge and checks the level one edge early and at the due edge. After the start edge the strobe pattern is fixed: the column strobe alone one edge later, then one row cycle (simultaneous) or four row cycles (walking), then release with refDone. Each expected pattern is compared edge by edge, sampled one nanosecond after the clock edge. Blocked grants are followed by two idle cycles in which the strobes and refReq must not move. Random intervals, styles and blocking patterns are drawn from a fixed seed.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  localparam int NUM_BANKS = 4;

  typedef struct packed {
    logic                 casLow;
    logic                 rasLow;
    logic [NUM_BANKS-1:0] csLow;
    logic                 done;
    logic                 walk;
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COL  = 2'd1,
    ST_ROW  = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int BANKS = NUM_BANKS
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqPend,
  input  logic    refGnt,
  input  logic    busIdle,
  input  logic    xferDone,
  input  logic    stagCfg,
  output logic    start,
  output strobe_t strb
);
  localparam int IDX_W = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BANKS - 1);

  seq_state_e       state;
  logic [IDX_W-1:0] bankIdx;
  logic             walkQ;

  assign start = (state == ST_IDLE) && reqPend && refGnt && busIdle && xferDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bankIdx <= '0;
      walkQ   <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_COL;
          walkQ   <= stagCfg;
          bankIdx <= '0;
        end
        ST_COL:  state <= ST_ROW;
        ST_ROW: begin
          if (!walkQ || bankIdx == LAST_IDX) state <= ST_FIN;
          else bankIdx <= bankIdx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb      = '0;
    strb.walk = walkQ;
    case (state)
      ST_COL: strb.casLow = 1'b1;
      ST_ROW: begin
        strb.casLow = 1'b1;
        strb.rasLow = 1'b1;
        for (int b = 0; b < BANKS; b++)
          strb.csLow[b] = walkQ ? (bankIdx == IDX_W'(b)) : 1'b1;
      end
      ST_FIN: strb.done = 1'b1;
      default: ;
    endcase
  end

  // R5
  grant_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !(reqPend && refGnt && busIdle && xferDone)) |=> (state == ST_IDLE));
endmodule

// File: rtl/refresh_dpath.sv
module refresh_dpath
  import refresh_pkg::*;
#(
  parameter int              BANKS    = NUM_BANKS,
  parameter int              CNT_W    = 16,
  parameter logic [CNT_W-1:0] DEF_IVAL = CNT_W'(512)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CNT_W-1:0] cfgInterval,
  input  logic             cfgStagger,
  input  logic             start,
  input  strobe_t          strb,
  output logic             reqPend,
  output logic             stagCfg,
  output logic [BANKS-1:0] csN,
  output logic             rasN,
  output logic             casN,
  output logic             refDone
);
  logic [CNT_W-1:0] intervalQ;
  logic [CNT_W-1:0] cnt;
  logic             tcHit;

  assign tcHit = (cnt == CNT_W'(1)) && !cfgWe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intervalQ <= DEF_IVAL;
      stagCfg   <= 1'b1;
      cnt       <= DEF_IVAL;
    end else if (cfgWe) begin
      intervalQ <= cfgInterval;
      stagCfg   <= cfgStagger;
      cnt       <= cfgInterval;
    end else if (cnt == CNT_W'(1)) begin
      cnt <= intervalQ;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       reqPend <= 1'b0;
    else if (tcHit)  reqPend <= 1'b1;
    else if (start)  reqPend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csN     <= '1;
      rasN    <= 1'b1;
      casN    <= 1'b1;
      refDone <= 1'b0;
    end else begin
      csN     <= ~strb.csLow[BANKS-1:0];
      rasN    <= ~strb.rasLow;
      casN    <= ~strb.casLow;
      refDone <= strb.done;
    end
  end

  logic walkSeen;
  always_ff @(posedge clk) begin
    if (!rstN) walkSeen <= 1'b0;
    else       walkSeen <= strb.walk;
  end

  // R2
  req_on_tc_chk: assert property (@(posedge clk) disable iff (!rstN)
    tcHit |=> reqPend);

  // R6
  col_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> (rasN && (&csN)));

  // R8
  one_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN && walkSeen) |-> ($countones(~csN) == 1));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (casN && (&csN) && refDone));
endmodule

// File: rtl/stagger_refresh_seq.sv
module stagger_refresh_seq
  import refresh_pkg::*;
#(
  parameter int               CNT_W    = 16,
  parameter logic [CNT_W-1:0] DEF_IVAL = CNT_W'(512)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [CNT_W-1:0]     cfgInterval,
  input  logic                 cfgStagger,
  input  logic                 refGnt,
  input  logic                 busIdle,
  input  logic                 xferDone,
  output logic                 refReq,
  output logic [NUM_BANKS-1:0] csN,
  output logic                 rasN,
  output logic                 casN,
  output logic                 refDone
);
  strobe_t strb;
  logic    start;
  logic    stagCfg;

  refresh_ctrl #(.BANKS(NUM_BANKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqPend(refReq), .refGnt(refGnt),
    .busIdle(busIdle), .xferDone(xferDone), .stagCfg(stagCfg),
    .start(start), .strb(strb)
  );

  refresh_dpath #(.BANKS(NUM_BANKS), .CNT_W(CNT_W), .DEF_IVAL(DEF_IVAL)) u_dpath (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgInterval(cfgInterval),
    .cfgStagger(cfgStagger), .start(start), .strb(strb),
    .reqPend(refReq), .stagCfg(stagCfg), .csN(csN), .rasN(rasN),
    .casN(casN), .refDone(refDone)
  );
endmodule

// File: tb/stagger_refresh_seq_tb.sv
module stagger_refresh_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [15:0] cfgInterval = '0;
  logic        cfgStagger = 1'b1;
  logic        refGnt = 1'b0;
  logic        busIdle = 1'b1;
  logic        xferDone = 1'b1;
  logic        refReq, rasN, casN, refDone;
  logic [3:0]  csN;
  int          errors = 0;
  int          checks = 0;

  always #2.5 clk = ~clk;

  stagger_refresh_seq u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgInterval(cfgInterval),
    .cfgStagger(cfgStagger), .refGnt(refGnt), .busIdle(busIdle),
    .xferDone(xferDone), .refReq(refReq), .csN(csN), .rasN(rasN),
    .casN(casN), .refDone(refDone)
  );

  function automatic logic [6:0] pack(logic [3:0] cs, logic r, logic c, logic d);
    return {cs, r, c, d};
  endfunction

  function automatic logic [3:0] expRowCs(logic walk, int k);
    return walk ? ~(4'b0001 << k) : 4'b0000;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic writeCfg(int ival, logic walk);
    cfgWe = 1'b1; cfgInterval = 16'(ival); cfgStagger = walk;
    step();
    cfgWe = 1'b0;
  endtask

  task automatic chkIdleOut(string req);
    chk(req, {25'd0, pack(csN, rasN, casN, refDone)}, {25'd0, pack(4'hF, 1'b1, 1'b1, 1'b0)});
  endtask

  // Measures edges from the loading edge to refReq rising (R2)
  task automatic measureReq(int n);
    for (int i = 1; i < n; i++) step();
    chk("R2 early", {31'd0, refReq}, 32'd0);
    step();
    chk("R2 due", {31'd0, refReq}, 32'd1);
  endtask

  task automatic runSeq(logic walk);
    refGnt = 1'b1; busIdle = 1'b1; xferDone = 1'b1;
    step();
    refGnt = 1'b0;
    chk("R4 req cleared", {31'd0, refReq}, 32'd0);
    chkIdleOut("R6 pre");
    step();
    chk("R6 col only", {25'd0, pack(csN, rasN, casN, refDone)}, {25'd0, pack(4'hF, 1'b1, 1'b0, 1'b0)});
    if (walk) begin
      for (int k = 0; k < 4; k++) begin
        step();
        chk("R8 walk row", {25'd0, pack(csN, rasN, casN, refDone)},
            {25'd0, pack(expRowCs(1'b1, k), 1'b0, 1'b0, 1'b0)});
      end
    end else begin
      step();
      chk("R7 all row", {25'd0, pack(csN, rasN, casN, refDone)},
          {25'd0, pack(expRowCs(1'b0, 0), 1'b0, 1'b0, 1'b0)});
    end
    step();
    chk("R9 release", {25'd0, pack(csN, rasN, casN, refDone)}, {25'd0, pack(4'hF, 1'b1, 1'b1, 1'b1)});
    step();
    chkIdleOut("R9 done one cycle");
  endtask

  // Grant offered while blocked; must be ignored (R5)
  task automatic blockedGrant(logic idl, logic xd, logic expReq);
    refGnt = 1'b1; busIdle = idl; xferDone = xd;
    step();
    refGnt = 1'b0; busIdle = 1'b1; xferDone = 1'b1;
    for (int i = 0; i < 2; i++) begin
      chkIdleOut("R5 ignored grant");
      chk("R5 req kept", {31'd0, refReq}, {31'd0, expReq});
      step();
    end
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(32'h5EED);
    repeat (3) step();
    chkIdleOut("R1 in reset");
    chk("R1 req in reset", {31'd0, refReq}, 32'd0);
    rstN = 1'b1;
    chkIdleOut("R1 after reset");
    // default interval 512 from reset
    measureReq(512);
    // default style is walking
    runSeq(1'b1);

    // programmed interval
    writeCfg(20, 1'b1);
    measureReq(20);
    // blocked grants
    writeCfg(0, 1'b0);
    blockedGrant(1'b0, 1'b1, 1'b1);
    blockedGrant(1'b1, 1'b0, 1'b1);
    blockedGrant(1'b0, 1'b0, 1'b1);
    runSeq(1'b0);

    // zero interval: no requests
    for (int i = 0; i < 120; i++) begin
      step();
      if (i % 30 == 0) chk("R3 no request", {31'd0, refReq}, 32'd0);
    end
    // grant with nothing pending is ignored
    blockedGrant(1'b1, 1'b1, 1'b0);

    // absorption: three expiries, one sequence
    writeCfg(10, 1'b1);
    for (int i = 0; i < 32; i++) step();
    chk("R4 pending", {31'd0, refReq}, 32'd1);
    writeCfg(0, 1'b1);
    runSeq(1'b1);
    blockedGrant(1'b1, 1'b1, 1'b0);
    chk("R4 single", {31'd0, refReq}, 32'd0);

    // constrained random rounds
    for (int r = 0; r < 24; r++) begin
      logic walk;
      int   n;
      int   nb;
      walk = 1'($urandom % 2);
      n    = 8 + int'($urandom % 30);
      writeCfg(n, walk);
      measureReq(n);
      writeCfg(0, walk);
      nb = int'($urandom % 3);
      for (int b = 0; b < nb; b++) begin
        logic idl;
        logic xd;
        idl = 1'($urandom % 2);
        xd  = idl ? 1'b0 : 1'($urandom % 2);
        blockedGrant(idl, xd, 1'b1);
      end
      runSeq(walk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule